// File: doc/BRIEF.md
# Synchronous Burst Memory Cycle Decoder

This block sits at the control edge of a synchronous burst memory. On every rising clock edge it samples two active-low address strobes (a processor-side strobe and a controller-side strobe), an active-low burst advance input, three chip selects of mixed polarity and the write controls. The write controls are an active-low all-bytes write, an active-low byte-write enable and one active-low select per byte lane. From these inputs it settles on exactly one cycle type for that clock. The possible types are deselect, begin-burst read or write, continue-burst read or write, and suspend-burst read or write.

The decoded cycle is registered and presented one clock later as a cycle code. Alongside the code come a load command for the external address and an advance command for the burst counter. The block also outputs a per-lane write mask and a flag that says whether the data lanes are driven, which is true on read-type cycles. The address counter, the storage array and the output timing sit in neighbouring blocks and use these outputs.

Top module: `burst_cycle_decoder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the outputs are cycleKind = 0 (deselect), loadAddr = 0, advAddr = 0, writeMask = 0 and readValid = 0.
- R2: Each decoded cycle appears on the outputs exactly one clock after the edge that sampled its inputs.
- R3: With selPrimN high, the processor-side strobe is ignored. If ctrlStrobeN is low in such a cycle, the cycle is a deselect (code 0).
- R4: With selPrimN low and procStrobeN low, the cycle is a deselect when the qualified enable (selHigh = 1 and selSecN = 0) is false. Otherwise it is a begin-burst read (code 1, loadAddr = 1, readValid = 1, writeMask = 0), whatever the write inputs are.
- R5: With selPrimN low, procStrobeN high and ctrlStrobeN low, the cycle is a begin-burst read (code 1) or a begin-burst write (code 2) according to the write decode, with loadAddr = 1, if the qualified enable is true. If the qualified enable is false, the cycle is a deselect.
- R6: With both strobes inactive (ctrlStrobeN high and procStrobeN high or ignored), advanceN low gives a continue cycle: code 3 for a read or 4 for a write, with advAddr = 1. advanceN high gives a suspend cycle: code 5 for a read or 6 for a write, with loadAddr = 0 and advAddr = 0.
- R7: selHigh and selSecN have no effect on continue and suspend cycles. They are only looked at when a strobe starts an access.
- R8: allWriteN low makes a non-deselect cycle that was not started by the processor-side strobe a write with writeMask = 4'b1111, regardless of laneWriteN and laneSelN.
- R9: With allWriteN high and laneWriteN low, writeMask bit i is 1 exactly when laneSelN[i] is 0, in any combination. If every laneSelN bit is high, or if laneWriteN is high, the cycle is a read.
- R10: readValid is 1 on every read-type cycle (codes 1, 3, 5) and 0 on write cycles and deselects. writeMask is 0 except on write cycles.
- R11: A continue or suspend request that follows a deselect, or that comes before any burst has begun since reset, is decoded as a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| procStrobeN | input | 1 | Processor-side address strobe, active low |
| ctrlStrobeN | input | 1 | Controller-side address strobe, active low |
| advanceN | input | 1 | Burst advance, active low |
| selPrimN | input | 1 | Primary chip select, active low; also gates the processor-side strobe |
| selHigh | input | 1 | Secondary chip select, active high |
| selSecN | input | 1 | Secondary chip select, active low |
| allWriteN | input | 1 | Write all lanes, active low |
| laneWriteN | input | 1 | Byte-write enable, active low |
| laneSelN | input | 4 | Per-lane write selects, active low |
| cycleKind | output | 3 | Decoded cycle code: 0 deselect, 1/2 begin read/write, 3/4 continue read/write, 5/6 suspend read/write |
| loadAddr | output | 1 | Load the external address into the burst counter |
| advAddr | output | 1 | Advance the burst counter |
| writeMask | output | 4 | Lanes written this cycle |
| readValid | output | 1 | Data lanes driven (read-type cycle) |

## Verification
The embedded assertions check four properties on every cycle. Load and advance are never issued together. Write lanes and the read flag are never active at the same time. A processor-strobe start never produces a write, and an all-bytes write always sets every mask bit. A continue or suspend is accepted only right after an accepted access. The strobe priority rules need the bench's reference model, which the bench compares on every clock through directed sequences and long randomized runs. The same holds for the cases where enables are ignored during a burst, for the exact per-lane mask patterns and for the one-clock output latency.

// File: rtl/burst_cycle_decoder_pkg.sv
package burst_cycle_decoder_pkg;

  typedef enum logic [2:0] {
    KIND_DESEL    = 3'd0,
    KIND_BEGIN_RD = 3'd1,
    KIND_BEGIN_WR = 3'd2,
    KIND_CONT_RD  = 3'd3,
    KIND_CONT_WR  = 3'd4,
    KIND_SUSP_RD  = 3'd5,
    KIND_SUSP_WR  = 3'd6
  } cycleKind_e;

  // Strobes from the control decode to the datapath
  typedef struct packed {
    logic access;      // cycle is not a deselect
    logic startBurst;  // new access at the external address
    logic advance;     // continue at the next address
    logic readOnly;    // started by the processor-side strobe
  } ctrlStrobes_t;

endpackage

// File: rtl/burst_cycle_ctrl.sv
module burst_cycle_ctrl
  import burst_cycle_decoder_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         procStrobeN,
  input  logic         ctrlStrobeN,
  input  logic         advanceN,
  input  logic         selPrimN,
  input  logic         selHigh,
  input  logic         selSecN,
  output ctrlStrobes_t strb
);

  logic burstActiveQ;
  logic qualEnable;
  logic procTake;
  logic ctrlTake;
  logic idleStrobes;
  logic startBurst;
  logic carryOn;

  // Secondary selects only matter when a strobe starts an access
  assign qualEnable  = selHigh && !selSecN;
  // Processor strobe is masked while the primary select is high
  assign procTake    = !selPrimN && !procStrobeN;
  assign ctrlTake    = !selPrimN && procStrobeN && !ctrlStrobeN;
  assign idleStrobes = ctrlStrobeN && (selPrimN || procStrobeN);
  assign startBurst  = (procTake || ctrlTake) && qualEnable;
  // Continue/suspend only extends a live burst
  assign carryOn     = idleStrobes && burstActiveQ;

  always_comb begin
    strb.access     = startBurst || carryOn;
    strb.startBurst = startBurst;
    strb.advance    = carryOn && !advanceN;
    strb.readOnly   = procTake;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) burstActiveQ <= 1'b0;
    else       burstActiveQ <= strb.access;
  end

  // R11: a carried-on cycle must follow an accepted access
  assert_carry_needs_live_burst_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.access && !strb.startBurst) |-> $past(strb.access));

endmodule

// File: rtl/burst_cycle_datapath.sv
module burst_cycle_datapath
  import burst_cycle_decoder_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strb,
  input  logic             allWriteN,
  input  logic             laneWriteN,
  input  logic [LANES-1:0] laneSelN,
  output cycleKind_e       kindQ,
  output logic             loadQ,
  output logic             advQ,
  output logic [LANES-1:0] maskQ,
  output logic             readValidQ
);

  logic [LANES-1:0] laneWr;
  logic             isWrite;
  cycleKind_e       kindD;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign laneWr[i] = !allWriteN || (!laneWriteN && !laneSelN[i]);
  end

  assign isWrite = strb.access && !strb.readOnly && (|laneWr);

  always_comb begin
    if (!strb.access)         kindD = KIND_DESEL;
    else if (strb.startBurst) kindD = isWrite ? KIND_BEGIN_WR : KIND_BEGIN_RD;
    else if (strb.advance)    kindD = isWrite ? KIND_CONT_WR  : KIND_CONT_RD;
    else                      kindD = isWrite ? KIND_SUSP_WR  : KIND_SUSP_RD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindQ      <= KIND_DESEL;
      loadQ      <= 1'b0;
      advQ       <= 1'b0;
      maskQ      <= '0;
      readValidQ <= 1'b0;
    end else begin
      kindQ      <= kindD;
      loadQ      <= strb.startBurst;
      advQ       <= strb.advance;
      maskQ      <= isWrite ? laneWr : '0;
      readValidQ <= strb.access && !isWrite;
    end
  end

  assert_load_adv_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(loadQ && advQ));

  assert_lanes_quiet_on_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    (|maskQ) |-> !readValidQ);

  assert_proc_start_reads_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.access && strb.readOnly) |=> (maskQ == '0) && readValidQ);

  assert_all_write_full_mask_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.access && !strb.readOnly && !allWriteN) |=> (&maskQ));

endmodule

// File: rtl/burst_cycle_decoder.sv
module burst_cycle_decoder
  import burst_cycle_decoder_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             procStrobeN,
  input  logic             ctrlStrobeN,
  input  logic             advanceN,
  input  logic             selPrimN,
  input  logic             selHigh,
  input  logic             selSecN,
  input  logic             allWriteN,
  input  logic             laneWriteN,
  input  logic [LANES-1:0] laneSelN,
  output logic [2:0]       cycleKind,
  output logic             loadAddr,
  output logic             advAddr,
  output logic [LANES-1:0] writeMask,
  output logic             readValid
);

  ctrlStrobes_t strb;
  cycleKind_e   kindQ;

  burst_cycle_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .procStrobeN (procStrobeN),
    .ctrlStrobeN (ctrlStrobeN),
    .advanceN    (advanceN),
    .selPrimN    (selPrimN),
    .selHigh     (selHigh),
    .selSecN     (selSecN),
    .strb        (strb)
  );

  burst_cycle_datapath #(.LANES(LANES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .allWriteN  (allWriteN),
    .laneWriteN (laneWriteN),
    .laneSelN   (laneSelN),
    .kindQ      (kindQ),
    .loadQ      (loadAddr),
    .advQ       (advAddr),
    .maskQ      (writeMask),
    .readValidQ (readValid)
  );

  assign cycleKind = kindQ;

endmodule

// File: tb/tb_burst_cycle_decoder.sv
module tb_burst_cycle_decoder;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic procStrobeN = 1'b1, ctrlStrobeN = 1'b1, advanceN = 1'b1;
  logic selPrimN = 1'b1, selHigh = 1'b0, selSecN = 1'b1;
  logic allWriteN = 1'b1, laneWriteN = 1'b1;
  logic [3:0] laneSelN = 4'hF;
  logic [2:0] cycleKind;
  logic loadAddr, advAddr, readValid;
  logic [3:0] writeMask;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference state and pending expectation
  bit modelActive = 0;
  bit havePending = 0;
  int expKind;
  logic [3:0] expMask;
  logic expRv, expLd, expAdv;
  string expTag;

  always #2 clk = ~clk;

  burst_cycle_decoder dut (
    .clk(clk), .rstN(rstN), .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .advanceN(advanceN), .selPrimN(selPrimN), .selHigh(selHigh), .selSecN(selSecN),
    .allWriteN(allWriteN), .laneWriteN(laneWriteN), .laneSelN(laneSelN),
    .cycleKind(cycleKind), .loadAddr(loadAddr), .advAddr(advAddr),
    .writeMask(writeMask), .readValid(readValid)
  );

  task automatic compareOut(input string tag, input int k, input logic [3:0] m,
                            input logic rv, input logic ld, input logic av);
    checks++;
    if (cycleKind !== 3'(k) || writeMask !== m || readValid !== rv ||
        loadAddr !== ld || advAddr !== av) begin
      errors++;
      $display("FAIL %s: kind=%0d mask=%b rv=%b ld=%b adv=%b expected kind=%0d mask=%b rv=%b ld=%b adv=%b",
               tag, cycleKind, writeMask, readValid, loadAddr, advAddr, k, m, rv, ld, av);
    end
  endtask

  // Behavioural model of one sampled cycle
  task automatic model(input string tag);
    bit eff, wr, start, carry, rdOnly;
    logic [3:0] lanes;
    eff = selHigh && !selSecN;
    lanes = !allWriteN ? 4'hF : (!laneWriteN ? ~laneSelN : 4'h0);
    wr = (lanes != 4'h0);
    start = 0; carry = 0; rdOnly = 0;
    if (selPrimN && !ctrlStrobeN) begin
      start = 0;                              // R3
    end else if (!selPrimN && !procStrobeN) begin
      start = eff; rdOnly = 1;                // R4
    end else if (!ctrlStrobeN) begin
      start = eff;                            // R5
    end else begin
      carry = modelActive;                    // R6, R7, R11
    end
    if (rdOnly) wr = 0;
    expLd = start;
    expAdv = carry && !advanceN;
    if (!start && !carry) begin
      expKind = 0; expMask = 0; expRv = 0;
    end else begin
      expMask = wr ? lanes : 4'h0;
      expRv = !wr;
      if (start) expKind = wr ? 2 : 1;
      else if (expAdv) expKind = wr ? 4 : 3;
      else expKind = wr ? 6 : 5;
    end
    modelActive = start || carry;
    expTag = tag;
    havePending = 1;
  endtask

  // R2: inputs applied at a falling edge are sampled at the next rising edge
  // and their result is compared at the following falling edge.
  task automatic cyc(input logic ps, input logic cs, input logic av, input logic e1,
                     input logic e2, input logic e3, input logic gw, input logic bw,
                     input logic [3:0] be, input string tag);
    @(negedge clk);
    if (havePending) compareOut(expTag, expKind, expMask, expRv, expLd, expAdv);
    procStrobeN = ps; ctrlStrobeN = cs; advanceN = av; selPrimN = e1;
    selHigh = e2; selSecN = e3; allWriteN = gw; laneWriteN = bw; laneSelN = be;
    model(tag);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      compareOut("R1", 0, 4'h0, 0, 0, 0);
    end
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compareOut("R1", 0, 4'h0, 0, 0, 0);

    //   ps cs av e1 e2 e3 gw bw be
    cyc(1, 1, 0, 0, 1, 0, 1, 1, 4'hF, "R11");   // continue before any burst
    cyc(1, 0, 0, 0, 1, 0, 1, 1, 4'hF, "R2");    // begin read via ctrl strobe
    cyc(1, 1, 0, 0, 1, 0, 1, 1, 4'hF, "R6");    // continue read
    cyc(1, 1, 0, 0, 0, 1, 1, 1, 4'hF, "R7");    // enables false, still continues
    cyc(1, 1, 1, 1, 0, 1, 1, 1, 4'hF, "R6");    // suspend read
    cyc(0, 0, 0, 1, 1, 0, 1, 1, 4'hF, "R3");    // primary high, ctrl low: deselect
    cyc(1, 1, 1, 0, 1, 0, 1, 1, 4'hF, "R11");   // suspend after deselect
    cyc(0, 1, 0, 1, 1, 0, 0, 1, 4'hF, "R3");    // proc strobe masked, no burst
    cyc(1, 0, 0, 0, 1, 0, 0, 1, 4'hF, "R8");    // begin write all lanes
    cyc(1, 1, 0, 0, 1, 0, 1, 0, 4'b1010, "R9"); // continue write lanes 0 and 2
    cyc(1, 1, 0, 0, 1, 0, 1, 0, 4'hF, "R9");    // byte enable, no lanes: read
    cyc(1, 1, 0, 0, 1, 0, 1, 1, 4'h0, "R9");    // byte enable high: read
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 4'h0, "R4");    // proc start ignores writes
    cyc(0, 1, 0, 0, 0, 0, 0, 1, 4'hF, "R4");    // proc with enable false
    cyc(1, 0, 0, 0, 1, 1, 0, 1, 4'hF, "R5");    // ctrl with enable false
    cyc(1, 0, 1, 0, 1, 0, 1, 0, 4'b0110, "R5"); // begin partial write
    cyc(1, 1, 1, 1, 0, 0, 0, 1, 4'hF, "R10");   // suspend write, lanes quiet
    cyc(1, 1, 1, 0, 1, 0, 1, 1, 4'hF, "R10");   // suspend read, lanes driven

    for (int n = 0; n < 4000; n++) begin
      logic [15:0] r;
      r = 16'($urandom);
      cyc(r[0] | r[1], r[2] | r[3], r[4], r[5] & r[6], r[7] | r[8], r[9] & r[10],
          r[11] | r[12], r[13], 4'($urandom), "R6/R9 random");
    end
    @(negedge clk);
    if (havePending) compareOut(expTag, expKind, expMask, expRv, expLd, expAdv);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule